// File: doc/BRIEF.md
# Invisible Speculative Load Buffer

This block sits between a load pipeline and the data cache. A speculative load gets its value without leaving any trace in the cache. The block sends the read to the cache port with a no-side-effect flag raised, so the cache must neither allocate a line nor touch replacement state. The returned value is kept, with its address, in a slot of a small circular queue, and it is passed back to the pipeline together with the slot number.

When the oldest load reaches in-order commit, the pipeline raises a commit request. The block then sends a fresh, visible load to the same address, and this load may fill the cache as usual. Once its data returns, the block compares it with the kept value. A match is reported as a pass and frees the oldest slot. A mismatch is reported as a squash: every slot is discarded, and the pipeline must re-run the load and all younger work. A value that changed and then changed back still passes, because only equality matters.

A flush input keeps only the given number of oldest slots. If a cache response belongs to a slot that was removed, it is swallowed. Only one cache access is outstanding at a time. DEPTH must be a power of two.

Back-pressure rules:
- The allocate port and the commit port are valid/ready. A transfer happens on a clock edge where both valid and ready are high.
- Valid must stay high until ready is seen.
- The cache request port is also valid/ready.
- The speculative-data output and the result output are single-cycle pulses with no ready. The pipeline must take them when they appear.

Top module: `spec_load_shield`

## Requirements
- R1: A speculative read issues a request in the same cycle as the allocate transfer, with mem_req_nofill=1 and the allocate address. alloc_ready is low while a cache access is outstanding, and no request with mem_req_nofill=0 is ever issued for an allocation.
- R2: One cycle after the cache response to a speculative read, spec_rsp_valid pulses. spec_rsp_data carries the returned value, and spec_rsp_slot carries the slot index. Slot indices start at 0 after reset and advance by one per allocation, modulo DEPTH.
- R3: A commit is accepted only when the oldest slot holds its data, no access is outstanding and flush_valid is low. In that cycle the block issues a request with mem_req_nofill=0 at the oldest slot's address.
- R4: One cycle after the validation response, res_valid pulses. res_ok is 1 exactly when the returned value equals the kept value, and a pass frees the oldest slot.
- R5: On a mismatch, squash=1 and res_ok=0 together with res_valid, and all slots are discarded. After that, commit_ready stays low until a new load is allocated.
- R6: A memory value that changes and then returns to the kept value before validation gives a pass.
- R7: Validations check slots in allocation order, each against its own address and value.
- R8: After DEPTH allocations without a commit, alloc_ready stays low.
- R9: A flush keeps the flush_keep oldest slots and removes the rest. A speculative response for a removed slot produces no spec_rsp_valid. A validation response after a flush with flush_keep=0 produces no res_valid.
- R10: After reset, res_valid, squash, spec_rsp_valid and mem_req_valid are 0. With mem_req_ready high, alloc_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_valid | input | 1 | Speculative load request |
| alloc_ready | output | 1 | Request can be taken |
| alloc_addr | input | AW | Load address |
| spec_rsp_valid | output | 1 | Speculative data pulse |
| spec_rsp_data | output | DW | Speculative value |
| spec_rsp_slot | output | log2(DEPTH) | Slot holding the load |
| commit_valid | input | 1 | Oldest load reached commit |
| commit_ready | output | 1 | Validation load issued |
| res_valid | output | 1 | Validation result pulse |
| res_ok | output | 1 | Values matched |
| squash | output | 1 | Values differed; re-execute |
| flush_valid | input | 1 | Pipeline flush |
| flush_keep | input | log2(DEPTH)+1 | Number of oldest slots kept |
| mem_req_valid | output | 1 | Cache request |
| mem_req_ready | input | 1 | Cache takes request |
| mem_req_addr | output | AW | Request address |
| mem_req_nofill | output | 1 | 1: no fill and no replacement update |
| mem_rsp_valid | input | 1 | Cache response |
| mem_rsp_data | input | DW | Response data |

## Verification
The bench builds the block with its defaults: DEPTH=8, AW=8 and DW=32. It drives only sixteen addresses and narrow data values, so value collisions and change-then-restore sequences occur often. With eight slots, both the full stall and pointer wrap-around are reached within a few hundred operations. A behavioural memory with a latency of one to three cycles can be rewritten between a read and its validation. A latency of three opens a window in which a flush can land while a response is still pending.

// File: rtl/sls_pkg.sv
package sls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SPEC = 2'd1,
    ST_VAL  = 2'd2
  } sls_state_e;
endpackage

// File: rtl/sls_queue.sv
module sls_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [AW-1:0]              push_addr,
  input  logic                       fill,
  input  logic [DW-1:0]              fill_data,
  input  logic                       pop,
  input  logic                       clear,
  input  logic                       trunc,
  input  logic [$clog2(DEPTH):0]     trunc_keep,
  output logic [AW-1:0]              head_addr,
  output logic [DW-1:0]              head_data,
  output logic                       head_dv,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic [$clog2(DEPTH)-1:0]   newest_idx
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;

  logic [CW-1:0]    head_q, tail_q, tail_mid, tail_n, head_n;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] dv_q;

  assign count      = tail_q - head_q;
  assign full       = (count == CW'(DEPTH));
  assign newest_idx = IW'(tail_q - CW'(1));
  assign head_addr  = addr_q[head_q[IW-1:0]];
  assign head_data  = data_q[head_q[IW-1:0]];
  assign head_dv    = (count != '0) && dv_q[head_q[IW-1:0]];

  always_comb begin
    tail_mid = (trunc && (trunc_keep < count)) ? head_q + trunc_keep : tail_q;
    tail_n   = push ? tail_q + CW'(1) : tail_mid;
    head_n   = pop ? head_q + CW'(1) : head_q;
    if (clear) head_n = tail_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      dv_q   <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
      if (push) dv_q[tail_q[IW-1:0]] <= 1'b0;
      if (fill) dv_q[newest_idx]     <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) addr_q[tail_q[IW-1:0]] <= push_addr;
    if (fill) data_q[newest_idx]     <= fill_data;
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_fill_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill |-> (count != '0) && !dv_q[newest_idx]);
  p_pop_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_dv);
endmodule

// File: rtl/sls_sequencer.sv
module sls_sequencer
  import sls_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_valid,
  output logic                     alloc_ready,
  input  logic [AW-1:0]            alloc_addr,
  input  logic                     commit_valid,
  output logic                     commit_ready,
  input  logic                     flush_valid,
  input  logic [$clog2(DEPTH):0]   flush_keep,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [AW-1:0]            mem_req_addr,
  output logic                     mem_req_nofill,
  input  logic                     mem_rsp_valid,
  input  logic [DW-1:0]            mem_rsp_data,
  output logic                     spec_rsp_valid,
  output logic [DW-1:0]            spec_rsp_data,
  output logic [$clog2(DEPTH)-1:0] spec_rsp_slot,
  output logic                     res_valid,
  output logic                     res_ok,
  output logic                     squash,
  input  logic [AW-1:0]            q_head_addr,
  input  logic [DW-1:0]            q_head_data,
  input  logic                     q_head_dv,
  input  logic [$clog2(DEPTH):0]   q_count,
  input  logic                     q_full,
  input  logic [$clog2(DEPTH)-1:0] q_newest_idx,
  output logic                     q_push,
  output logic                     q_fill,
  output logic                     q_pop,
  output logic                     q_clear
);
  localparam int IW = $clog2(DEPTH);

  sls_state_e state_q, state_n;
  logic drop_q, dropped, kill_now, idle, head_go, val_rsp, match;

  assign idle    = (state_q == ST_IDLE);
  assign head_go = idle && !flush_valid && commit_valid && q_head_dv;

  assign mem_req_valid  = head_go || (idle && !flush_valid && alloc_valid && !q_full);
  assign mem_req_addr   = head_go ? q_head_addr : alloc_addr;
  assign mem_req_nofill = !head_go;
  assign commit_ready   = head_go && mem_req_ready;
  assign alloc_ready    = idle && !flush_valid && !q_full && !head_go && mem_req_ready;

  assign q_push = alloc_valid && alloc_ready;

  assign kill_now = flush_valid &&
                    ((state_q == ST_SPEC) ? (flush_keep < q_count) : (flush_keep == '0));
  assign dropped  = drop_q || kill_now;
  assign match    = (mem_rsp_data == q_head_data);
  assign val_rsp  = (state_q == ST_VAL) && mem_rsp_valid && !dropped;

  assign q_fill  = (state_q == ST_SPEC) && mem_rsp_valid && !dropped;
  assign q_pop   = val_rsp && match;
  assign q_clear = val_rsp && !match;

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_IDLE: begin
        if (commit_ready)    state_n = ST_VAL;
        else if (q_push)     state_n = ST_SPEC;
      end
      default: if (mem_rsp_valid) state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      drop_q         <= 1'b0;
      spec_rsp_valid <= 1'b0;
      spec_rsp_data  <= '0;
      spec_rsp_slot  <= '0;
      res_valid      <= 1'b0;
      res_ok         <= 1'b0;
      squash         <= 1'b0;
    end else begin
      state_q        <= state_n;
      drop_q         <= idle ? 1'b0 : (dropped && !mem_rsp_valid);
      spec_rsp_valid <= q_fill;
      if (q_fill) begin
        spec_rsp_data <= mem_rsp_data;
        spec_rsp_slot <= IW'(q_newest_idx);
      end
      res_valid <= val_rsp;
      res_ok    <= val_rsp && match;
      squash    <= val_rsp && !match;
    end
  end

  p_one_outstanding_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> !mem_req_valid);
  p_spec_invisible_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |-> (mem_req_valid && mem_req_nofill && mem_req_addr == alloc_addr));
  p_val_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && commit_ready) |-> (!mem_req_nofill && mem_req_addr == q_head_addr));
  p_res_follows_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(mem_rsp_valid));
  p_squash_is_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> (res_valid && !res_ok));
  p_excl_results_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && spec_rsp_valid));
endmodule

// File: rtl/spec_load_shield.sv
module spec_load_shield #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_valid,
  output logic                     alloc_ready,
  input  logic [AW-1:0]            alloc_addr,
  output logic                     spec_rsp_valid,
  output logic [DW-1:0]            spec_rsp_data,
  output logic [$clog2(DEPTH)-1:0] spec_rsp_slot,
  input  logic                     commit_valid,
  output logic                     commit_ready,
  output logic                     res_valid,
  output logic                     res_ok,
  output logic                     squash,
  input  logic                     flush_valid,
  input  logic [$clog2(DEPTH):0]   flush_keep,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [AW-1:0]            mem_req_addr,
  output logic                     mem_req_nofill,
  input  logic                     mem_rsp_valid,
  input  logic [DW-1:0]            mem_rsp_data
);
  localparam int IW = $clog2(DEPTH);

  logic [AW-1:0] q_head_addr;
  logic [DW-1:0] q_head_data;
  logic          q_head_dv, q_full, q_push, q_fill, q_pop, q_clear;
  logic [IW:0]   q_count;
  logic [IW-1:0] q_newest_idx;

  sls_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(q_push), .push_addr(alloc_addr),
    .fill(q_fill), .fill_data(mem_rsp_data),
    .pop(q_pop), .clear(q_clear),
    .trunc(flush_valid), .trunc_keep(flush_keep),
    .head_addr(q_head_addr), .head_data(q_head_data), .head_dv(q_head_dv),
    .count(q_count), .full(q_full), .newest_idx(q_newest_idx)
  );

  sls_sequencer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_addr(alloc_addr),
    .commit_valid(commit_valid), .commit_ready(commit_ready),
    .flush_valid(flush_valid), .flush_keep(flush_keep),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_nofill(mem_req_nofill),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .spec_rsp_valid(spec_rsp_valid), .spec_rsp_data(spec_rsp_data),
    .spec_rsp_slot(spec_rsp_slot),
    .res_valid(res_valid), .res_ok(res_ok), .squash(squash),
    .q_head_addr(q_head_addr), .q_head_data(q_head_data), .q_head_dv(q_head_dv),
    .q_count(q_count), .q_full(q_full), .q_newest_idx(q_newest_idx),
    .q_push(q_push), .q_fill(q_fill), .q_pop(q_pop), .q_clear(q_clear)
  );
endmodule

// File: tb/tb_spec_load_shield.sv
module tb_spec_load_shield;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int WD_LIMIT = 150000;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, commit_valid = 0, flush_valid = 0;
  logic [AW-1:0] alloc_addr = '0;
  logic [3:0] flush_keep = '0;
  logic mem_req_ready = 1, mem_rsp_valid = 0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic alloc_ready, commit_ready, spec_rsp_valid, res_valid, res_ok, squash;
  logic [DW-1:0] spec_rsp_data;
  logic [2:0] spec_rsp_slot;
  logic mem_req_valid, mem_req_nofill;
  logic [AW-1:0] mem_req_addr;

  spec_load_shield #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  int fill_cnt = 0, lat_cfg = 1, pend = 0;
  logic [AW-1:0] last_fill_addr = '0;
  logic [3:0] paddr = '0;
  logic [DW-1:0] mem [16];
  logic [AW-1:0] m_addr [$];
  logic [DW-1:0] m_data [$];
  int exp_head = 0, exp_tail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural memory, latency lat_cfg cycles
  always @(negedge clk) begin
    #2;
    if (pend > 0) begin
      pend = pend - 1;
      mem_rsp_valid = (pend == 0);
      if (pend == 0) mem_rsp_data = mem[paddr];
    end else mem_rsp_valid = 0;
    if (mem_req_valid && mem_req_ready) begin
      paddr = mem_req_addr[3:0];
      pend = lat_cfg;
      if (!mem_req_nofill) begin
        fill_cnt = fill_cnt + 1;
        last_fill_addr = mem_req_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_match(input logic [DW-1:0] kept, input logic [DW-1:0] now);
    return kept == now;
  endfunction

  task automatic alloc_issue(input logic [AW-1:0] a, output bit took);
    took = 0;
    @(negedge clk);
    alloc_valid = 1; alloc_addr = a;
    for (int i = 0; i < 4 && !took; i++) begin
      #3;
      if (alloc_ready) took = 1;
      else @(negedge clk);
    end
    @(posedge clk); #1;
    alloc_valid = 0;
    if (took) begin
      m_addr.push_back(a); m_data.push_back(mem[a[3:0]]);
      exp_tail++;
    end
  endtask

  task automatic alloc_one(input logic [AW-1:0] a);
    bit took, seen;
    int f0;
    f0 = fill_cnt;
    alloc_issue(a, took);
    chk(took, "R1 alloc accepted", took, 1);
    seen = 0;
    for (int i = 0; i < 8 && !seen; i++) begin
      @(negedge clk); #4;
      if (spec_rsp_valid) begin
        seen = 1;
        chk(spec_rsp_data == m_data[m_data.size()-1], "R2 spec data",
            spec_rsp_data, m_data[m_data.size()-1]);
        chk(spec_rsp_slot == 3'((exp_tail - 1) % DEPTH), "R2 slot",
            spec_rsp_slot, (exp_tail - 1) % DEPTH);
      end
    end
    chk(seen, "R2 spec response", seen, 1);
    chk(fill_cnt == f0, "R1 no fill during speculation", fill_cnt - f0, 0);
  endtask

  task automatic commit_one();
    bit took, seen, e;
    int f0;
    logic [AW-1:0] ea;
    ea = m_addr[0];
    e = exp_match(m_data[0], mem[ea[3:0]]);
    f0 = fill_cnt;
    took = 0;
    @(negedge clk);
    commit_valid = 1;
    for (int i = 0; i < 4 && !took; i++) begin
      #3;
      if (commit_ready) begin
        took = 1;
        chk(!mem_req_nofill && mem_req_addr == ea, "R3 visible load at head addr R7",
            mem_req_addr, ea);
      end else @(negedge clk);
    end
    @(posedge clk); #1;
    commit_valid = 0;
    chk(took, "R3 commit accepted", took, 1);
    seen = 0;
    for (int i = 0; i < 8 && !seen; i++) begin
      @(negedge clk); #4;
      if (res_valid) begin
        seen = 1;
        chk(res_ok == e, e ? "R4 pass R6" : "R5 mismatch", res_ok, e);
        chk(squash == !e, "R5 squash flag", squash, !e);
      end
    end
    chk(seen, "R4 result produced", seen, 1);
    chk(fill_cnt == f0 + 1 && last_fill_addr == ea, "R3 one fill", fill_cnt - f0, 1);
    if (e) begin
      void'(m_addr.pop_front()); void'(m_data.pop_front()); exp_head++;
    end else begin
      m_addr.delete(); m_data.delete(); exp_head = exp_tail;
    end
  endtask

  task automatic flush_to(input int k);
    @(negedge clk);
    flush_valid = 1; flush_keep = 4'(k);
    @(posedge clk); #1;
    flush_valid = 0;
    if (k < m_addr.size()) begin
      while (m_addr.size() > k) begin
        void'(m_addr.pop_back()); void'(m_data.pop_back());
      end
      exp_tail = exp_head + k;
    end
  endtask

  task automatic expect_commit_refused(input string tag);
    bit any;
    any = 0;
    @(negedge clk);
    commit_valid = 1;
    for (int i = 0; i < 4; i++) begin
      #3; if (commit_ready) any = 1;
      @(negedge clk);
    end
    commit_valid = 0;
    chk(!any, tag, any, 0);
  endtask

  task automatic expect_full(input string tag);
    bit any;
    any = 0;
    @(negedge clk);
    alloc_valid = 1;
    for (int i = 0; i < 4; i++) begin
      #3; if (alloc_ready) any = 1;
      @(negedge clk);
    end
    alloc_valid = 0;
    chk(!any, tag, any, 0);
  endtask

  task automatic quiet_window(input bit want_spec, output bit saw);
    saw = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #4;
      if (want_spec ? spec_rsp_valid : res_valid) saw = 1;
    end
  endtask

  initial begin
    wait (cyc == WD_LIMIT);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit took, saw;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) mem[i] = 32'(i * 3 + 1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #3;
    chk(!res_valid && !squash && !spec_rsp_valid && !mem_req_valid, "R10 idle outputs",
        {res_valid, squash, spec_rsp_valid, mem_req_valid}, 0);
    chk(alloc_ready, "R10 alloc_ready", alloc_ready, 1);

    // R4 plain pass, R5 mismatch
    alloc_one(8'd2); commit_one();
    alloc_one(8'd3); mem[3] = 32'hdead; commit_one();
    expect_commit_refused("R5 slots discarded after squash");

    // R6 change and restore
    alloc_one(8'd4); mem[4] = 32'h55; mem[4] = 32'(4 * 3 + 1); commit_one();

    // R7 order: only second address changes
    alloc_one(8'd5); alloc_one(8'd6); mem[6] = 32'h77;
    commit_one(); commit_one();

    // R8 full
    for (int i = 0; i < DEPTH; i++) alloc_one(8'(i));
    expect_full("R8 stall when full");
    for (int i = 0; i < DEPTH; i++) commit_one();

    // R9 truncation
    for (int i = 0; i < 4; i++) alloc_one(8'(i + 8));
    flush_to(2);
    for (int i = 0; i < DEPTH - 2; i++) alloc_one(8'(i));
    expect_full("R9 flush kept two slots");
    flush_to(0);

    // R9 speculative response after removal
    lat_cfg = 3;
    alloc_one(8'd1); alloc_one(8'd2);
    alloc_issue(8'd3, took);
    flush_to(2);
    quiet_window(1, saw);
    chk(!saw, "R9 dropped spec response", saw, 0);
    commit_one(); commit_one();
    expect_commit_refused("R9 removed slot not validated");

    // R9 validation dropped by full flush
    alloc_one(8'd7);
    @(negedge clk); commit_valid = 1;
    @(posedge clk); #1 commit_valid = 0;
    flush_to(0);
    quiet_window(0, saw);
    chk(!saw, "R9 dropped validation result", saw, 0);
    exp_head = exp_tail;
    for (int i = 0; i < DEPTH; i++) alloc_one(8'(i));
    expect_full("R9 empty after full flush");
    flush_to(0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      lat_cfg = 1 + int'($urandom % 3);
      op = int'($urandom % 5);
      if (op <= 1 && m_addr.size() < DEPTH) alloc_one(8'($urandom % 16));
      else if (op == 2 && m_addr.size() > 0) commit_one();
      else if (op == 3) mem[$urandom % 16] = 32'($urandom % 3);
      else if (op == 4 && ($urandom % 4) == 0) flush_to(int'($urandom % (m_addr.size() + 1)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule